// File: doc/BRIEF.md
# Buffered compare/capture register pair

This block is one slice of a 16-bit timer channel. It keeps a general register and a companion buffer register. A per-pair enable bit turns buffering on or off. A mode bit sets what the general register does. In output compare mode it is compared with an external free-running counter. In input capture mode it latches that counter when an external capture signal rises.

With buffering on, the data moves between the two registers in a direction set by the mode. On a compare match the buffer value is loaded into the general register, so software can queue the next compare value ahead of time. On a capture, the previous general register value is pushed into the buffer while the new counter value is latched, so two captures are held at once.

A processor port can read and write both registers a word at a time or one byte lane at a time. A standby request returns both registers to all ones. Counter clocking, pin waveforms, interrupts and the other channels are handled outside this slice.

Top module: `tmr_pair_slice`

## Requirements
- R1: After reset, both the general register and the buffer register read 0xFFFF, and match_pulse is low.
- R2: When standby is high at a clock edge, both registers become 0xFFFF at that edge. Standby overrides every hardware transfer and every processor write in that cycle.
- R3: A processor write updates the register picked by cpu_sel (0 = general, 1 = buffer) at the clock edge. cpu_be[1] enables bits 15:8 and cpu_be[0] enables bits 7:0. Lanes that are not enabled keep their value, so cpu_be = 0 changes nothing. cpu_rdata shows the selected register combinationally, and reading has no side effects.
- R4: In compare mode (mode_cap = 0), match_pulse goes high for exactly one cycle, in the cycle after the first clock edge at which count_in equals the general register. It does not pulse again while the equality persists. It never pulses in capture mode (mode_cap = 1).
- R5: In compare mode with buf_en = 1, at the edge that raises match_pulse the general register loads the buffer value. The buffer keeps its value.
- R6: In compare mode with buf_en = 0, a compare match leaves both registers unchanged.
- R7: In capture mode, cap_in passes through a two-stage synchronizer. When cap_in rises just after a clock edge, the general register takes the count_in value present at the third rising clock edge after that point. A level held high, or a falling edge, causes no further capture.
- R8: In capture mode with buf_en = 1, the buffer takes the old general register value at the same edge as the capture.
- R9: In capture mode with buf_en = 0, a capture leaves the buffer unchanged.
- R10: When a hardware transfer and a processor write target the same register in the same cycle, the hardware transfer wins.
- R11: Changing mode_cap alone does not alter either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| standby | input | 1 | Synchronous force of both registers to all ones |
| mode_cap | input | 1 | 0 = output compare, 1 = input capture |
| buf_en | input | 1 | Buffering enable for this pair |
| count_in | input | 16 | Free-running counter value |
| cap_in | input | 1 | Asynchronous capture input, rising edge active |
| cpu_wr | input | 1 | Processor write strobe |
| cpu_sel | input | 1 | Register select: 0 general, 1 buffer |
| cpu_be | input | 2 | Byte-lane enables: bit 1 high byte, bit 0 low byte |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Selected register value |
| match_pulse | output | 1 | One-cycle compare match pulse |

## Verification
Processor writes and compare-mode transfers are due one edge after their cause. The bench drives inputs on the falling edge and reads back on the next falling edge, so match_pulse and the register contents are checked half a cycle after the edge that updates them. A capture is due at the third rising edge after cap_in rises. The bench changes count_in on every cycle of that window and checks that the general register still holds its old value after the second edge and holds the third value after the third edge. Sweeps of count_in across the compare value are checked cycle by cycle against a model in the bench that tracks the previous-cycle equality.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;
  typedef enum logic {
    SEL_GEN = 1'b0,
    SEL_BUF = 1'b1
  } tmr_sel_e;

  typedef enum logic {
    MODE_CMP = 1'b0,
    MODE_CAP = 1'b1
  } tmr_mode_e;

  localparam int unsigned LANE_W = 8;
endpackage

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_in,
  output logic cap_rise
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], cap_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign cap_rise = sync_q[STAGES-1] & ~last_q;

  // R7: the strobe from one edge lasts a single cycle
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_rise |=> !cap_rise);
endmodule

// File: rtl/tmr_match_det.sv
module tmr_match_det #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         standby,
  input  logic         mode_cap,
  input  logic [W-1:0] count_in,
  input  logic [W-1:0] gen_q,
  output logic         cmp_evt,
  output logic         match_pulse
);
  import tmr_pair_pkg::*;

  logic hit_c;
  logic hit_d;

  function automatic logic equal_in_mode(input logic m, input logic [W-1:0] a,
                                         input logic [W-1:0] b);
    return (tmr_mode_e'(m) == MODE_CMP) && (a == b);
  endfunction

  assign hit_c   = equal_in_mode(mode_cap, count_in, gen_q);
  assign cmp_evt = hit_c & ~hit_d & ~standby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_d       <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      hit_d       <= hit_c;
      match_pulse <= cmp_evt;
    end
  end

  p_match_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |=> !match_pulse);
  p_no_match_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cap |=> !match_pulse);
endmodule

// File: rtl/tmr_pair_regs.sv
module tmr_pair_regs #(
  parameter int unsigned W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 standby,
  input  logic                 buf_en,
  input  logic                 cmp_evt,
  input  logic                 cap_evt,
  input  logic [W-1:0]         count_in,
  input  logic                 cpu_wr,
  input  logic                 cpu_sel,
  input  logic [W/8-1:0]       cpu_be,
  input  logic [W-1:0]         cpu_wdata,
  output logic [W-1:0]         gen_q,
  output logic [W-1:0]         buf_q
);
  import tmr_pair_pkg::*;
  localparam int unsigned LANES = W / LANE_W;

  logic wr_gen;
  logic wr_buf;

  function automatic logic [W-1:0] lane_merge(input logic [W-1:0] old_v,
                                              input logic [W-1:0] new_v,
                                              input logic [LANES-1:0] be);
    logic [W-1:0] r;
    r = old_v;
    for (int i = 0; i < LANES; i++) begin
      if (be[i]) r[i*LANE_W +: LANE_W] = new_v[i*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  assign wr_gen = cpu_wr && (tmr_sel_e'(cpu_sel) == SEL_GEN);
  assign wr_buf = cpu_wr && (tmr_sel_e'(cpu_sel) == SEL_BUF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= '1;
    end else if (standby) begin
      gen_q <= '1;
    end else if (cmp_evt && buf_en) begin
      gen_q <= buf_q;
    end else if (cap_evt) begin
      gen_q <= count_in;
    end else if (wr_gen) begin
      gen_q <= lane_merge(gen_q, cpu_wdata, cpu_be);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '1;
    end else if (standby) begin
      buf_q <= '1;
    end else if (cap_evt && buf_en) begin
      buf_q <= gen_q;
    end else if (wr_buf) begin
      buf_q <= lane_merge(buf_q, cpu_wdata, cpu_be);
    end
  end

  p_standby_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (gen_q == '1) && (buf_q == '1));
  p_cmp_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && buf_en) |=> (gen_q == $past(buf_q)) && (buf_q == $past(buf_q)));
  p_cmp_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && !buf_en && !cpu_wr) |=> $stable(gen_q) && $stable(buf_q));
  p_cap_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> gen_q == $past(count_in));
  p_cap_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && buf_en) |=> buf_q == $past(gen_q));
  p_cap_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && !buf_en && !cpu_wr) |=> $stable(buf_q));
  p_hw_over_cpu_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && buf_en && wr_gen) |=> gen_q == $past(buf_q));
endmodule

// File: rtl/tmr_pair_slice.sv
module tmr_pair_slice #(
  parameter int unsigned W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           standby,
  input  logic           mode_cap,
  input  logic           buf_en,
  input  logic [W-1:0]   count_in,
  input  logic           cap_in,
  input  logic           cpu_wr,
  input  logic           cpu_sel,
  input  logic [W/8-1:0] cpu_be,
  input  logic [W-1:0]   cpu_wdata,
  output logic [W-1:0]   cpu_rdata,
  output logic           match_pulse
);
  import tmr_pair_pkg::*;

  logic         cap_rise;
  logic         cap_evt;
  logic         cmp_evt;
  logic [W-1:0] gen_q;
  logic [W-1:0] buf_q;

  tmr_cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_in   (cap_in),
    .cap_rise (cap_rise)
  );

  assign cap_evt = (tmr_mode_e'(mode_cap) == MODE_CAP) && cap_rise && !standby;

  tmr_match_det #(.W(W)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .standby     (standby),
    .mode_cap    (mode_cap),
    .count_in    (count_in),
    .gen_q       (gen_q),
    .cmp_evt     (cmp_evt),
    .match_pulse (match_pulse)
  );

  tmr_pair_regs #(.W(W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby   (standby),
    .buf_en    (buf_en),
    .cmp_evt   (cmp_evt),
    .cap_evt   (cap_evt),
    .count_in  (count_in),
    .cpu_wr    (cpu_wr),
    .cpu_sel   (cpu_sel),
    .cpu_be    (cpu_be),
    .cpu_wdata (cpu_wdata),
    .gen_q     (gen_q),
    .buf_q     (buf_q)
  );

  assign cpu_rdata = (tmr_sel_e'(cpu_sel) == SEL_BUF) ? buf_q : gen_q;

  // R4 and R7: the two transfer events never coincide
  p_events_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmp_evt && cap_evt));
endmodule

// File: tb/test_tmr_pair_slice.sv
module test_tmr_pair_slice;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0;
  logic        mode_cap = 1'b1;
  logic        buf_en = 1'b0;
  logic [15:0] count_in = 16'h0000;
  logic        cap_in = 1'b0;
  logic        cpu_wr = 1'b0;
  logic        cpu_sel = 1'b0;
  logic [1:0]  cpu_be = 2'b00;
  logic [15:0] cpu_wdata = 16'h0000;
  logic [15:0] cpu_rdata;
  logic        match_pulse;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [15:0] gm, bm;   // bench model of the two registers
  bit ph;                // previous-cycle equality

  always #10 clk = ~clk;

  tmr_pair_slice i_tmr_pair_slice (
    .clk(clk), .rst_n(rst_n), .standby(standby), .mode_cap(mode_cap),
    .buf_en(buf_en), .count_in(count_in), .cap_in(cap_in), .cpu_wr(cpu_wr),
    .cpu_sel(cpu_sel), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .match_pulse(match_pulse)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, output logic [15:0] v);
    cpu_sel = sel;
    #1;
    v = cpu_rdata;
  endtask

  task automatic check_regs(input string req);
    logic [15:0] v;
    rd(1'b0, v); check({req, " gen"}, v, gm);
    rd(1'b1, v); check({req, " buf"}, v, bm);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] o, input logic [15:0] d,
                                        input logic [1:0] be);
    return ((be[1] ? d : o) & 16'hFF00) | ((be[0] ? d : o) & 16'h00FF);
  endfunction

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = sel; cpu_be = be; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_wr = 1'b0;
    if (sel) bm = merge(bm, d, be); else gm = merge(gm, d, be);
  endtask

  task automatic cmp_step(input logic [15:0] k, input string req);
    bit hit, ep;
    count_in = k;
    @(posedge clk);
    @(negedge clk);
    hit = (k == gm);
    ep = hit && !ph;
    if (ep && buf_en) gm = bm;
    ph = hit;
    check(req, {15'd0, match_pulse}, {15'd0, ep});
  endtask

  task automatic cap_round(input logic en, input logic [15:0] base);
    logic [15:0] old_g;
    old_g = gm;
    buf_en = en;
    cap_in = 1'b1; count_in = base;
    @(posedge clk); @(negedge clk);
    count_in = base + 16'd1;
    @(posedge clk); @(negedge clk);
    check_regs("R7 no early capture");
    count_in = base + 16'd2;
    @(posedge clk); @(negedge clk);
    gm = base + 16'd2;
    if (en) bm = old_g;
    check_regs(en ? "R7/R8 capture with shift" : "R7/R9 capture no shift");
    count_in = base + 16'd9;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check_regs("R7 held level no recapture");
    cap_in = 1'b0;
    repeat (4) begin @(posedge clk); @(negedge clk); end
    check_regs("R7 falling edge no capture");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    gm = 16'hFFFF; bm = 16'hFFFF; ph = 0;
    repeat (3) @(negedge clk);
    check_regs("R1 reset");
    check("R1 match low", {15'd0, match_pulse}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: lane sweep over both registers
    for (int p = 0; p < 6; p++) begin
      for (int s = 0; s < 2; s++) begin
        for (int b = 0; b < 4; b++) begin
          wr(s[0], b[1:0], 16'h1234 * (p + 1) + 16'(b * 16'h0F0F));
          check_regs("R3 byte lane write");
        end
      end
    end
    rd(1'b0, v); rd(1'b0, v2);
    check("R3 read no side effect", v2, v);

    // R6 / R4: compare without buffering
    wr(1'b0, 2'b11, 16'h0010); wr(1'b1, 2'b11, 16'h0020);
    buf_en = 1'b0; mode_cap = 1'b0; ph = 0;
    for (int k = 0; k <= 16'h30; k++) cmp_step(16'(k), "R4/R6 compare sweep");
    mode_cap = 1'b1; count_in = 16'h0000;
    check_regs("R6 compare no transfer");

    // R5: compare with buffering
    buf_en = 1'b1; mode_cap = 1'b0; ph = 0;
    for (int k = 0; k <= 16'h30; k++) cmp_step(16'(k), "R4/R5 buffered compare sweep");
    mode_cap = 1'b1; count_in = 16'h0000;
    check_regs("R5 buffer loaded into general");

    // R4: held equality pulses once
    buf_en = 1'b0;
    wr(1'b0, 2'b11, 16'h0080);
    mode_cap = 1'b0; ph = 0;
    repeat (5) cmp_step(16'h0080, "R4 held equality single pulse");
    mode_cap = 1'b1; count_in = 16'h0000;

    // R4: no pulse in capture mode
    count_in = 16'h0080;
    repeat (3) begin
      @(posedge clk); @(negedge clk);
      check("R4 no match in capture mode", {15'd0, match_pulse}, 16'd0);
    end
    count_in = 16'h0000;

    // R7/R8/R9 capture rounds
    for (int r = 0; r < 6; r++) cap_round(r[0], 16'h0300 + 16'(r * 16'h0111));

    // R10: compare transfer beats processor write
    wr(1'b0, 2'b11, 16'h0040); wr(1'b1, 2'b11, 16'h0055);
    buf_en = 1'b1;
    @(negedge clk);
    mode_cap = 1'b0; count_in = 16'h0040;
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_be = 2'b11; cpu_wdata = 16'h7777;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0; mode_cap = 1'b1; count_in = 16'h0000;
    gm = 16'h0055;
    check("R10 compare match pulse", {15'd0, match_pulse}, 16'd1);
    check_regs("R10 compare beats write");

    // R10: capture shift beats processor write to buffer
    wr(1'b0, 2'b11, 16'h0A0A);
    cap_in = 1'b1; count_in = 16'h0700;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b1; cpu_sel = 1'b1; cpu_be = 2'b11; cpu_wdata = 16'h1111;
    @(posedge clk); @(negedge clk);
    cpu_wr = 1'b0; cap_in = 1'b0;
    bm = gm; gm = 16'h0700;
    check_regs("R10 capture beats write");
    repeat (3) @(negedge clk);

    // R11: mode toggles leave contents alone
    wr(1'b0, 2'b11, 16'h2222); wr(1'b1, 2'b11, 16'h3333);
    count_in = 16'h0001;
    for (int t = 0; t < 4; t++) begin
      mode_cap = t[0];
      @(posedge clk); @(negedge clk);
      check_regs("R11 mode change");
    end
    mode_cap = 1'b1;

    // R2: standby overrides a write
    wr(1'b0, 2'b11, 16'h1357); wr(1'b1, 2'b11, 16'h2468);
    @(negedge clk);
    standby = 1'b1;
    cpu_wr = 1'b1; cpu_sel = 1'b0; cpu_be = 2'b11; cpu_wdata = 16'h0000;
    @(posedge clk); @(negedge clk);
    standby = 1'b0; cpu_wr = 1'b0;
    gm = 16'hFFFF; bm = 16'hFFFF;
    check_regs("R2 standby fill");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule